// File: doc/BRIEF.md
# Frame Buffer Scan Address Generator

This block produces the DWORD address from which a raster display engine fetches pixel data as the scan moves down the screen. A frame start pulse loads the programmed base address. Each line start pulse moves the fetch pointer to the start of the next frame buffer line, which lies one pitch further on. Each fetch-advance strobe steps the pointer along the current line.

Three display modes act on the same address path. The first is a split-screen compare, which restarts fetching at address zero from a programmed display line onward. The second is line doubling, in which every odd display line fetches the previous line again, so a frame buffer of half height fills the full display. The third is chain-4 stepping, in which only every fourth DWORD is read. A flag marks each line that is a replica of the line above it. Pixel formatting, memory arbitration and sync timing belong to neighbouring blocks.

Top module: `fb_scan_addr`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `fetch_addr` is 0, `repeat_line` is 0 and the display line index is 0.
- R2: `frame_start` takes priority over every other input. On the next edge it sets `fetch_addr` and the line base to `base_addr`, the line index to 0 and `repeat_line` to 0.
- R3: A `fetch_adv` strobe with no `line_start` or `frame_start` in the same cycle adds 1 to `fetch_addr` when `chain4_en` is 0, and adds 4 when it is 1. The sum wraps modulo 2^ADDR_W.
- R4: On `line_start`, with no split match and no repeated line, the line index increments, the line base grows by `line_pitch`, and `fetch_addr` takes the new line base. A `fetch_adv` in the same cycle is ignored.
- R5: With `dbl_en` set, a `line_start` that moves to an odd display line (bit 0 of the new index is 1) reloads `fetch_addr` with the unchanged previous line base and sets `repeat_line`. `repeat_line` stays high for the whole of that line. The next even line advances by the pitch and clears the flag, so two repeated lines never follow each other.
- R6: With `split_en` set, a `line_start` whose new display line index equals `split_line` sets both the line base and `fetch_addr` to 0 and clears `repeat_line`. Later lines advance from 0.
- R7: The line index counts display lines, including repeated ones. The split compare and the odd/even test for doubling therefore both work in display-line units.
- R8: With `split_en` clear, a line index equal to `split_line` has no effect on the address.
- R9: Both outputs are registers. They change only on the rising edge after the input that causes the change.
- R10: In a cycle with no `frame_start`, `line_start` or `fetch_adv`, `fetch_addr` and `repeat_line` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Start of frame pulse |
| line_start | input | 1 | Start of display line pulse |
| fetch_adv | input | 1 | Advance fetch pointer strobe |
| base_addr | input | ADDR_W | Frame base DWORD address |
| line_pitch | input | ADDR_W | DWORD distance between frame buffer lines |
| split_line | input | LINE_W | Display line index at which fetching restarts at 0 |
| split_en | input | 1 | Enable split-screen compare |
| dbl_en | input | 1 | Enable line doubling |
| chain4_en | input | 1 | Enable every-fourth-DWORD stepping |
| fetch_addr | output | ADDR_W | Current fetch DWORD address |
| repeat_line | output | 1 | High during a replicated line |

## Verification
The bench probes the following corner cases:
- **Split compare with doubling on.** A design that counted frame buffer lines instead of display lines would restart at zero on the wrong display line.
- **Line start and fetch strobe together.** A design that let the fetch win would leave the pointer inside the previous line.
- **Chain-4 stepping near the top of the address space.** A design with the wrong step size or a saturating adder would miss the wrapped value.
- **Repeated lines under doubling.** A design that advanced the base on a repeated line would skip frame buffer lines. One that dropped the flag early would mark only part of the replica.
- **Compare value matched with split disabled.** A design that ignored the enable would restart at zero.

A behavioural model compares both outputs on every cycle, across directed and random traffic.

// File: rtl/fbsa_pkg.sv
package fbsa_pkg;
  // Kind of line entered at a line start
  typedef enum logic [1:0] {
    LK_ADVANCE = 2'd0,
    LK_REPEAT  = 2'd1,
    LK_SPLIT   = 2'd2
  } line_kind_t;
endpackage

// File: rtl/fbsa_line_ctl.sv
module fbsa_line_ctl #(
  parameter int LINE_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frame_start,
  input  logic                   line_start,
  input  logic                   split_en,
  input  logic                   dbl_en,
  input  logic [LINE_W-1:0]      split_line,
  output fbsa_pkg::line_kind_t   kind,
  output logic                   rep_q
);
  import fbsa_pkg::*;

  logic [LINE_W-1:0] cnt_q;
  logic [LINE_W-1:0] cnt_nxt;

  // Display line index of the line about to start
  assign cnt_nxt = cnt_q + 1'b1;

  always_comb begin
    if (split_en && (cnt_nxt == split_line))
      kind = LK_SPLIT;
    else if (dbl_en && cnt_nxt[0])
      kind = LK_REPEAT;
    else
      kind = LK_ADVANCE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rep_q <= 1'b0;
    end else if (frame_start) begin
      cnt_q <= '0;
      rep_q <= 1'b0;
    end else if (line_start) begin
      cnt_q <= cnt_nxt;
      rep_q <= (kind == LK_REPEAT);
    end
  end

  AST_RPT_NEEDS_DBL: assert property (@(posedge clk) disable iff (rst)
    $rose(rep_q) |-> ($past(dbl_en) && $past(line_start))); // R5

  AST_RPT_NOT_TWICE: assert property (@(posedge clk) disable iff (rst)
    (rep_q && line_start && !frame_start) |=> !rep_q); // R5

  AST_RPT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!line_start && !frame_start) |=> $stable(rep_q)); // R10
endmodule

// File: rtl/fbsa_addr_path.sv
module fbsa_addr_path #(
  parameter int ADDR_W = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_start,
  input  logic                 line_start,
  input  logic                 fetch_adv,
  input  logic                 chain4_en,
  input  fbsa_pkg::line_kind_t kind,
  input  logic [ADDR_W-1:0]    base_addr,
  input  logic [ADDR_W-1:0]    line_pitch,
  output logic [ADDR_W-1:0]    addr_q
);
  import fbsa_pkg::*;

  localparam logic [ADDR_W-1:0] STEP_ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_FOUR = ADDR_W'(4);

  logic [ADDR_W-1:0] lbase_q;
  logic [ADDR_W-1:0] lbase_adv;
  logic [ADDR_W-1:0] step;

  assign lbase_adv = lbase_q + line_pitch;
  assign step      = chain4_en ? STEP_FOUR : STEP_ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      lbase_q <= '0;
      addr_q  <= '0;
    end else if (frame_start) begin
      lbase_q <= base_addr;
      addr_q  <= base_addr;
    end else if (line_start) begin
      unique case (kind)
        LK_SPLIT: begin
          lbase_q <= '0;
          addr_q  <= '0;
        end
        LK_REPEAT: begin
          addr_q  <= lbase_q;
        end
        default: begin
          lbase_q <= lbase_adv;
          addr_q  <= lbase_adv;
        end
      endcase
    end else if (fetch_adv) begin
      addr_q <= addr_q + step;
    end
  end

  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (addr_q == $past(base_addr))); // R2

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
    (fetch_adv && !line_start && !frame_start) |=>
      (addr_q == $past(addr_q) + ($past(chain4_en) ? STEP_FOUR : STEP_ONE))); // R3

  AST_SPLIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (line_start && !frame_start && kind == LK_SPLIT) |=> (addr_q == '0)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!fetch_adv && !line_start && !frame_start) |=> $stable(addr_q)); // R10
endmodule

// File: rtl/fb_scan_addr.sv
module fb_scan_addr #(
  parameter int ADDR_W = 24,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              fetch_adv,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] line_pitch,
  input  logic [LINE_W-1:0] split_line,
  input  logic              split_en,
  input  logic              dbl_en,
  input  logic              chain4_en,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              repeat_line
);
  fbsa_pkg::line_kind_t kind;
  logic                 rep_q;
  logic [ADDR_W-1:0]    addr_q;

  fbsa_line_ctl #(.LINE_W(LINE_W)) i_line_ctl (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .line_start  (line_start),
    .split_en    (split_en),
    .dbl_en      (dbl_en),
    .split_line  (split_line),
    .kind        (kind),
    .rep_q       (rep_q)
  );

  fbsa_addr_path #(.ADDR_W(ADDR_W)) i_addr_path (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .line_start  (line_start),
    .fetch_adv   (fetch_adv),
    .chain4_en   (chain4_en),
    .kind        (kind),
    .base_addr   (base_addr),
    .line_pitch  (line_pitch),
    .addr_q      (addr_q)
  );

  assign fetch_addr  = addr_q;
  assign repeat_line = rep_q;

  AST_FRAME_CLEARS_RPT: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !repeat_line); // R2

  AST_RPT_AT_BASE: assert property (@(posedge clk) disable iff (rst)
    $rose(repeat_line) |-> !$past(frame_start)); // R9
endmodule

// File: tb/test_fb_scan_addr.sv
`timescale 1ns/1ps
module test_fb_scan_addr;
  localparam int AW = 24;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_start = 1'b0, line_start = 1'b0, fetch_adv = 1'b0;
  logic [AW-1:0] base_addr = '0, line_pitch = '0;
  logic [LW-1:0] split_line = '0;
  logic          split_en = 1'b0, dbl_en = 1'b0, chain4_en = 1'b0;
  logic [AW-1:0] fetch_addr;
  logic          repeat_line;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int            m_line;
  logic [AW-1:0] m_base, m_addr;
  logic          m_rep;

  always #2.5 clk = ~clk;

  fb_scan_addr #(.ADDR_W(AW), .LINE_W(LW)) i_fb_scan_addr (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
    .fetch_adv(fetch_adv), .base_addr(base_addr), .line_pitch(line_pitch),
    .split_line(split_line), .split_en(split_en), .dbl_en(dbl_en),
    .chain4_en(chain4_en), .fetch_addr(fetch_addr), .repeat_line(repeat_line)
  );

  task automatic model_update();
    int n;
    if (rst) begin
      m_line = 0; m_base = '0; m_addr = '0; m_rep = 1'b0;
    end else if (frame_start) begin
      m_line = 0; m_base = base_addr; m_addr = base_addr; m_rep = 1'b0;
    end else if (line_start) begin
      n = (m_line + 1) % (1 << LW);
      m_line = n;
      if (split_en && n == int'(split_line)) begin
        m_base = '0; m_addr = '0; m_rep = 1'b0;
      end else if (dbl_en && (n % 2 == 1)) begin
        m_addr = m_base; m_rep = 1'b1;
      end else begin
        m_base = m_base + line_pitch; m_addr = m_base; m_rep = 1'b0;
      end
    end else if (fetch_adv) begin
      m_addr = m_addr + (chain4_en ? AW'(4) : AW'(1));
    end
  endtask

  task automatic compare();
    checks++;
    if (fetch_addr !== m_addr) begin
      failures++;
      $display("FAIL %s fetch_addr actual=%h expected=%h", cur_req, fetch_addr, m_addr);
    end
    checks++;
    if (repeat_line !== m_rep) begin
      failures++;
      $display("FAIL %s repeat_line actual=%b expected=%b", cur_req, repeat_line, m_rep);
    end
  endtask

  task automatic check_const(input string req, input logic [AW-1:0] got_a,
                             input logic [AW-1:0] exp_a, input logic got_r,
                             input logic exp_r);
    checks++;
    if (got_a !== exp_a || got_r !== exp_r) begin
      failures++;
      $display("FAIL %s actual=%h/%b expected=%h/%b", req, got_a, got_r, exp_a, exp_r);
    end
  endtask

  // One clock: drive at negedge, model at posedge, compare at next negedge (R9)
  task automatic cyc(input logic fs, input logic ls, input logic fa);
    frame_start = fs; line_start = ls; fetch_adv = fa;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
    frame_start = 1'b0; line_start = 1'b0; fetch_adv = 1'b0;
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    cur_req = "R1";
    for (int i = 0; i < 3; i++) cyc(0, 0, 0);
    rst = 1'b0;
    cyc(0, 0, 0);
    check_const("R1", fetch_addr, '0, repeat_line, 1'b0);

    // Plain stepping and line advance
    cur_req = "R2"; base_addr = 24'h001000; line_pitch = 24'h000040;
    cyc(1, 0, 0);
    check_const("R2", fetch_addr, 24'h001000, repeat_line, 1'b0);
    cur_req = "R3";
    for (int i = 0; i < 3; i++) cyc(0, 0, 1);
    check_const("R3", fetch_addr, 24'h001003, repeat_line, 1'b0);
    cur_req = "R10"; cyc(0, 0, 0); cyc(0, 0, 0);
    check_const("R10", fetch_addr, 24'h001003, repeat_line, 1'b0);
    cur_req = "R4"; cyc(0, 1, 0);
    check_const("R4", fetch_addr, 24'h001040, repeat_line, 1'b0);
    cyc(0, 1, 1);
    check_const("R4", fetch_addr, 24'h001080, repeat_line, 1'b0);
    cur_req = "R3"; chain4_en = 1'b1; cyc(0, 0, 1); cyc(0, 0, 1);
    check_const("R3", fetch_addr, 24'h001088, repeat_line, 1'b0);

    // Line doubling
    cur_req = "R5"; chain4_en = 1'b0; dbl_en = 1'b1;
    base_addr = 24'h002000; line_pitch = 24'h000100;
    cyc(1, 0, 0); cyc(0, 0, 1); cyc(0, 0, 1);
    cyc(0, 1, 0);
    check_const("R5", fetch_addr, 24'h002000, repeat_line, 1'b1);
    cyc(0, 0, 1); cyc(0, 0, 1);
    check_const("R5", fetch_addr, 24'h002002, repeat_line, 1'b1);
    cyc(0, 1, 0);
    check_const("R5", fetch_addr, 24'h002100, repeat_line, 1'b0);
    cyc(0, 1, 0);
    check_const("R5", fetch_addr, 24'h002100, repeat_line, 1'b1);

    // Split without doubling
    cur_req = "R6"; dbl_en = 1'b0; split_en = 1'b1; split_line = 12'd3;
    base_addr = 24'h003000; line_pitch = 24'h000010;
    cyc(1, 0, 0); cyc(0, 1, 0); cyc(0, 1, 0);
    check_const("R6", fetch_addr, 24'h003020, repeat_line, 1'b0);
    cyc(0, 1, 0);
    check_const("R6", fetch_addr, 24'h000000, repeat_line, 1'b0);
    cyc(0, 1, 0);
    check_const("R6", fetch_addr, 24'h000010, repeat_line, 1'b0);

    // Split in display-line units with doubling
    cur_req = "R7"; dbl_en = 1'b1; split_line = 12'd4;
    cyc(1, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0);
    check_const("R7", fetch_addr, 24'h003010, repeat_line, 1'b1);
    cyc(0, 1, 0);
    check_const("R7", fetch_addr, 24'h000000, repeat_line, 1'b0);
    cyc(0, 1, 0);
    check_const("R7", fetch_addr, 24'h000000, repeat_line, 1'b1);

    // Compare value hit while split disabled
    cur_req = "R8"; dbl_en = 1'b0; split_en = 1'b0; split_line = 12'd2;
    cyc(1, 0, 0); cyc(0, 1, 0); cyc(0, 1, 0);
    check_const("R8", fetch_addr, 24'h003020, repeat_line, 1'b0);

    // Frame start beats everything
    cur_req = "R2"; dbl_en = 1'b1; cyc(0, 1, 0);
    base_addr = 24'h00ABC0; cyc(1, 1, 1);
    check_const("R2", fetch_addr, 24'h00ABC0, repeat_line, 1'b0);

    // Wrap at the top of the address space
    cur_req = "R3"; dbl_en = 1'b0; chain4_en = 1'b1; base_addr = 24'hFFFFFE;
    cyc(1, 0, 0); cyc(0, 0, 1);
    check_const("R3", fetch_addr, 24'h000002, repeat_line, 1'b0);

    // Random traffic against the model
    cur_req = "R9";
    for (int i = 0; i < 3000; i++) begin
      if (i % 60 == 0) begin
        base_addr  = AW'($urandom);
        line_pitch = AW'($urandom_range(1, 512));
        split_line = LW'($urandom_range(0, 12));
        split_en   = 1'($urandom);
        dbl_en     = 1'($urandom);
        chain4_en  = 1'($urandom);
      end
      cyc(($urandom_range(0, 99) < 2), ($urandom_range(0, 9) < 2),
          1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule